// File: doc/BRIEF.md
# Exception Entry and Return Controller

This block holds the exception state of a MIPS-style core: the Status and Cause registers, the exception return address (EPC) and the error return address (ErrorEPC). The pipeline presents the PC of the instruction at hand together with a delay-slot flag. It can also raise a synchronous exception carrying a 5-bit code and a vector class, pulse a non-maskable interrupt, or pulse a return-from-exception. Five external interrupt pins and a timer line feed the pending-interrupt field. When an unmasked interrupt is pending and the gates allow it, the block takes the interrupt by itself.

Every entry or return produces a one-cycle `redirect` pulse with the new fetch address. This pulse appears in the cycle after the request. A simple register port lets software read and write the four registers. A load-linked flag is kept here as well, because a return must clear it.

Top module: `exc_ctrl`

## Requirements
- R1: After reset Status reads 0x00400004 (BEV at bit 22 and ERL at bit 2 set, all other bits zero), Cause reads 0 while no interrupt line is high, and `redirect` and `ll_flag` are 0.
- R2: A synchronous exception makes `redirect` 1 for one cycle after the request, with `redirect_pc` = base + offset. The base is 0x80000000 when BEV=0 and 0xBFC00200 when BEV=1. The offset is 0x000 for `exc_kind`=1 (TLB refill), 0x080 for `exc_kind`=2 (64-bit TLB refill) and 0x180 for `exc_kind`=0 or 3.
- R3: On a synchronous exception, `exc_code` is written to Cause bits 6:2. Cause bits 29:28 take `exc_cop` when the code is 11 (coprocessor unusable) and 0 otherwise.
- R4: On entry with EXL=0, EPC takes `pc_in`, or `pc_in`-4 when `in_slot`=1, and Cause bit 31 takes `in_slot`.
- R5: Every synchronous entry sets Status.EXL. When EXL was already 1, EPC and Cause bit 31 keep their values.
- R6: The Cause field at bits 15:8 holds the pending interrupts. Bits 9:8 are the only Cause bits software can write. Bits 14:10 follow `irq_pins[4:0]` and bit 15 follows `timer_irq`.
- R7: With IE=1, EXL=0, ERL=0 and any pending bit masked in by Status bits 15:8, the block takes an interrupt one cycle later. Taking it sets code 0 and EXL, saves `pc_in` in EPC, and redirects to base + 0x180.
- R8: No interrupt is taken while IE=0 or while no pending bit is enabled in the mask.
- R9: An NMI redirects to 0xBFC00000, sets ERL and BEV, and saves `pc_in` in ErrorEPC.
- R10: A return with ERL=1 redirects to ErrorEPC and clears only ERL. With ERL=0 it redirects to EPC and clears EXL.
- R11: `ll_set` sets `ll_flag`, and a return clears it.
- R12: The events have a fixed order of precedence: NMI, then synchronous exception, then interrupt, then return. A software register write in a cycle with any of these events is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pc_in | input | 32 | PC of the current instruction |
| in_slot | input | 1 | Current instruction sits in a branch delay slot |
| exc_req | input | 1 | Synchronous exception request |
| exc_code | input | 5 | Exception code |
| exc_kind | input | 2 | Vector class: 0 general, 1 refill, 2 64-bit refill |
| exc_cop | input | 2 | Coprocessor number for code 11 |
| nmi_req | input | 1 | Non-maskable interrupt / soft reset request |
| irq_pins | input | 5 | External interrupt lines |
| timer_irq | input | 1 | Timer interrupt line |
| eret | input | 1 | Return-from-exception strobe |
| ll_set | input | 1 | Sets the load-linked flag |
| csr_we | input | 1 | Register write enable |
| csr_sel | input | 2 | 0 Status, 1 Cause, 2 EPC, 3 ErrorEPC |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data (combinational) |
| redirect | output | 1 | One-cycle fetch redirect pulse |
| redirect_pc | output | 32 | New fetch address |
| ll_flag | output | 1 | Load-linked flag |

## Verification
The bench builds the block with its default vector parameters: a normal base of 0x80000000, a bootstrap base of 0xBFC00200 and an NMI address of 0xBFC00000. With these values every base and offset pairing yields a distinct, recognisable address, so each of the six vector combinations is checked exactly. The directed scenarios reach the nested cases: entry while EXL is already set, an NMI stacked on an open exception and unwound by two returns, simultaneous NMI and exception, and a software write colliding with an entry.

// File: rtl/exc_ctrl.sv
module exc_ctrl #(
  parameter logic [31:0] NORM_BASE = 32'h8000_0000,
  parameter logic [31:0] BOOT_BASE = 32'hBFC0_0200,
  parameter logic [31:0] NMI_VEC   = 32'hBFC0_0000,
  parameter logic [31:0] OFF_GEN   = 32'h0000_0180,
  parameter logic [31:0] OFF_REF   = 32'h0000_0000,
  parameter logic [31:0] OFF_XREF  = 32'h0000_0080
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] pc_in,
  input  logic        in_slot,
  input  logic        exc_req,
  input  logic [4:0]  exc_code,
  input  logic [1:0]  exc_kind,
  input  logic [1:0]  exc_cop,
  input  logic        nmi_req,
  input  logic [4:0]  irq_pins,
  input  logic        timer_irq,
  input  logic        eret,
  input  logic        ll_set,
  input  logic        csr_we,
  input  logic [1:0]  csr_sel,
  input  logic [31:0] csr_wdata,
  output logic [31:0] csr_rdata,
  output logic        redirect,
  output logic [31:0] redirect_pc,
  output logic        ll_flag
);
  localparam logic [4:0] CODE_CPU = 5'd11;

  logic        st_ie, st_exl, st_erl, st_bev;
  logic [1:0]  st_ksu;
  logic [7:0]  st_im;
  logic        ca_bd;
  logic [1:0]  ca_ce, ca_ipsw;
  logic [4:0]  ca_code;
  logic [31:0] epc, errorepc;

  logic [7:0]  ip;
  logic        irq_go, do_nmi, do_exc, do_irq, do_ret, any_ev, sw_wr;
  logic [31:0] entry_pc, base, off;

  assign ip       = {timer_irq, irq_pins, ca_ipsw};
  assign irq_go   = st_ie && !st_exl && !st_erl && |(ip & st_im);
  assign do_nmi   = nmi_req;
  assign do_exc   = exc_req && !nmi_req;
  assign do_irq   = irq_go && !nmi_req && !exc_req;
  assign do_ret   = eret && !nmi_req && !exc_req && !irq_go;
  assign any_ev   = nmi_req || exc_req || irq_go || eret;
  assign sw_wr    = csr_we && !any_ev;
  assign entry_pc = in_slot ? pc_in - 32'd4 : pc_in;
  assign base     = st_bev ? BOOT_BASE : NORM_BASE;

  always_comb begin
    case (exc_kind)
      2'd1:    off = OFF_REF;
      2'd2:    off = OFF_XREF;
      default: off = OFF_GEN;
    endcase
    if (!do_exc) off = OFF_GEN;
  end

  always_comb begin
    case (csr_sel)
      2'd0: csr_rdata = {9'b0, st_bev, 6'b0, st_im, 3'b0, st_ksu, st_erl, st_exl, st_ie};
      2'd1: csr_rdata = {ca_bd, 1'b0, ca_ce, 12'b0, ip, 1'b0, ca_code, 2'b0};
      2'd2: csr_rdata = epc;
      default: csr_rdata = errorepc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_ie <= 1'b0; st_exl <= 1'b0; st_erl <= 1'b1; st_bev <= 1'b1;
      st_ksu <= 2'b00; st_im <= 8'h00;
    end else if (do_nmi) begin
      st_erl <= 1'b1;
      st_bev <= 1'b1;
    end else if (do_exc || do_irq) begin
      st_exl <= 1'b1;
    end else if (do_ret) begin
      if (st_erl) st_erl <= 1'b0;
      else        st_exl <= 1'b0;
    end else if (sw_wr && csr_sel == 2'd0) begin
      st_ie  <= csr_wdata[0];
      st_exl <= csr_wdata[1];
      st_erl <= csr_wdata[2];
      st_ksu <= csr_wdata[4:3];
      st_im  <= csr_wdata[15:8];
      st_bev <= csr_wdata[22];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ca_bd <= 1'b0; ca_ce <= 2'b0; ca_code <= 5'd0; ca_ipsw <= 2'b0;
      epc <= 32'd0; errorepc <= 32'd0;
    end else if (do_nmi) begin
      errorepc <= pc_in;
    end else if (do_exc || do_irq) begin
      ca_code <= do_exc ? exc_code : 5'd0;
      ca_ce   <= (do_exc && exc_code == CODE_CPU) ? exc_cop : 2'b0;
      if (!st_exl) begin
        epc   <= entry_pc;
        ca_bd <= in_slot;
      end
    end else if (sw_wr) begin
      case (csr_sel)
        2'd1: ca_ipsw <= csr_wdata[9:8];
        2'd2: epc <= csr_wdata;
        2'd3: errorepc <= csr_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      redirect <= 1'b0; redirect_pc <= 32'd0; ll_flag <= 1'b0;
    end else begin
      redirect <= do_nmi || do_exc || do_irq || do_ret;
      if (do_nmi)                redirect_pc <= NMI_VEC;
      else if (do_exc || do_irq) redirect_pc <= base + off;
      else if (do_ret)           redirect_pc <= st_erl ? errorepc : epc;
      if (do_ret)      ll_flag <= 1'b0;
      else if (ll_set) ll_flag <= 1'b1;
    end
  end

  p_entry_sets_exl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req && !nmi_req) |=> st_exl);
  p_epc_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req && !nmi_req && st_exl) |=> ($stable(epc) && $stable(ca_bd)));
  p_nmi_vector_r9: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |=> (redirect && redirect_pc == NMI_VEC && st_erl && st_bev));
  p_irq_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_go && !nmi_req && !exc_req) |=> (redirect && st_exl && ca_code == 5'd0));
  p_ret_clears_ll_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (eret && !nmi_req && !exc_req && !irq_go) |=> (redirect && !ll_flag));
endmodule

// File: tb/exc_ctrl_test.sv
module exc_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pc_in = '0;
  logic        in_slot = 1'b0, exc_req = 1'b0, nmi_req = 1'b0;
  logic [4:0]  exc_code = '0, irq_pins = '0;
  logic [1:0]  exc_kind = '0, exc_cop = '0, csr_sel = '0;
  logic        timer_irq = 1'b0, eret = 1'b0, ll_set = 1'b0, csr_we = 1'b0;
  logic [31:0] csr_wdata = '0, csr_rdata, redirect_pc;
  logic        redirect, ll_flag;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  exc_ctrl uut (.clk(clk), .rst_n(rst_n), .pc_in(pc_in), .in_slot(in_slot),
    .exc_req(exc_req), .exc_code(exc_code), .exc_kind(exc_kind), .exc_cop(exc_cop),
    .nmi_req(nmi_req), .irq_pins(irq_pins), .timer_irq(timer_irq), .eret(eret),
    .ll_set(ll_set), .csr_we(csr_we), .csr_sel(csr_sel), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .redirect(redirect), .redirect_pc(redirect_pc),
    .ll_flag(ll_flag));

  always #10 clk = ~clk;

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] v);
    csr_sel = sel; #1; v = csr_rdata;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    csr_we = 1'b1; csr_sel = sel; csr_wdata = d;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic take_exc(input logic [1:0] kind, input logic [4:0] code,
                          input logic [1:0] cop, input logic [31:0] pc, input logic slot);
    exc_req = 1'b1; exc_kind = kind; exc_code = code; exc_cop = cop;
    pc_in = pc; in_slot = slot;
    @(negedge clk);
    exc_req = 1'b0; in_slot = 1'b0;
  endtask

  task automatic do_ret();
    eret = 1'b1; @(negedge clk); eret = 1'b0;
  endtask

  task automatic do_nmi(input logic [31:0] pc);
    nmi_req = 1'b1; pc_in = pc; @(negedge clk); nmi_req = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(2'd0, v); chk("R1 status", v, 32'h0040_0004);
    rd(2'd1, v); chk("R1 cause", v, 32'h0);
    chk("R1 redirect", {31'b0, redirect}, 32'd0);
    chk("R1 ll", {31'b0, ll_flag}, 32'd0);
  endtask

  task automatic t_vectors();
    wr(2'd0, 32'h0);
    take_exc(2'd0, 5'd8, 2'd0, 32'h1000, 1'b0);
    chk("R2 redirect", {31'b0, redirect}, 32'd1);
    chk("R2 gen bev0", redirect_pc, 32'h8000_0180);
    do_ret(); chk("R10 ret epc", redirect_pc, 32'h1000);
    @(negedge clk); chk("R2 one-cycle pulse", {31'b0, redirect}, 32'd0);
    take_exc(2'd1, 5'd2, 2'd0, 32'h1000, 1'b0); chk("R2 refill bev0", redirect_pc, 32'h8000_0000);
    do_ret();
    take_exc(2'd2, 5'd2, 2'd0, 32'h1000, 1'b0); chk("R2 xrefill bev0", redirect_pc, 32'h8000_0080);
    do_ret();
    wr(2'd0, 32'h0040_0000);
    take_exc(2'd3, 5'd9, 2'd0, 32'h1000, 1'b0); chk("R2 gen bev1", redirect_pc, 32'hBFC0_0380);
    do_ret();
    take_exc(2'd1, 5'd3, 2'd0, 32'h1000, 1'b0); chk("R2 refill bev1", redirect_pc, 32'hBFC0_0200);
    do_ret();
    take_exc(2'd2, 5'd3, 2'd0, 32'h1000, 1'b0); chk("R2 xrefill bev1", redirect_pc, 32'hBFC0_0280);
    do_ret();
    wr(2'd0, 32'h0);
  endtask

  task automatic t_cause_code();
    logic [31:0] v;
    take_exc(2'd0, 5'd11, 2'd2, 32'h1100, 1'b0);
    rd(2'd1, v); chk("R3 code 11", {27'b0, v[6:2]}, 32'd11);
    chk("R3 cop field", {30'b0, v[29:28]}, 32'd2);
    do_ret();
    take_exc(2'd0, 5'd13, 2'd3, 32'h1100, 1'b0);
    rd(2'd1, v); chk("R3 code 13", {27'b0, v[6:2]}, 32'd13);
    chk("R3 cop cleared", {30'b0, v[29:28]}, 32'd0);
    do_ret();
  endtask

  task automatic t_epc();
    logic [31:0] v;
    take_exc(2'd0, 5'd10, 2'd0, 32'h2004, 1'b1);
    rd(2'd2, v); chk("R4 epc slot", v, 32'h2000);
    rd(2'd1, v); chk("R4 bd set", {31'b0, v[31]}, 32'd1);
    take_exc(2'd0, 5'd12, 2'd0, 32'h3000, 1'b0);
    rd(2'd2, v); chk("R5 epc kept", v, 32'h2000);
    rd(2'd1, v); chk("R5 bd kept", {31'b0, v[31]}, 32'd1);
    chk("R5 code updated", {27'b0, v[6:2]}, 32'd12);
    rd(2'd0, v); chk("R5 exl set", {31'b0, v[1]}, 32'd1);
    do_ret(); chk("R10 ret to slot branch", redirect_pc, 32'h2000);
    rd(2'd0, v); chk("R10 exl cleared", {31'b0, v[1]}, 32'd0);
    take_exc(2'd0, 5'd8, 2'd0, 32'h2200, 1'b0);
    rd(2'd2, v); chk("R4 epc plain", v, 32'h2200);
    rd(2'd1, v); chk("R4 bd clear", {31'b0, v[31]}, 32'd0);
    do_ret();
  endtask

  task automatic t_pending();
    logic [31:0] v;
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, v); chk("R6 sw ip only", v, 32'h0000_0320);
    irq_pins = 5'b10101; timer_irq = 1'b1; #1;
    rd(2'd1, v); chk("R6 hw ip", {24'b0, v[15:8]}, 32'hD7);
    irq_pins = '0; timer_irq = 1'b0;
    wr(2'd1, 32'h0);
    rd(2'd1, v); chk("R6 sw ip cleared", {24'b0, v[15:8]}, 32'h0);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    pc_in = 32'h4440; irq_pins = 5'b00001;
    wr(2'd0, 32'h0000_FF00);
    @(negedge clk); chk("R8 ie off", {31'b0, redirect}, 32'd0);
    wr(2'd0, 32'h0000_0001);
    @(negedge clk); chk("R8 mask off", {31'b0, redirect}, 32'd0);
    rd(2'd0, v); chk("R8 exl untouched", {31'b0, v[1]}, 32'd0);
    wr(2'd0, 32'h0000_0401);
    chk("R7 not before gate", {31'b0, redirect}, 32'd0);
    @(negedge clk);
    chk("R7 taken", {31'b0, redirect}, 32'd1);
    chk("R7 vector", redirect_pc, 32'h8000_0180);
    rd(2'd1, v); chk("R7 code 0", {27'b0, v[6:2]}, 32'd0);
    rd(2'd2, v); chk("R7 epc", v, 32'h4440);
    irq_pins = '0;
    @(negedge clk); chk("R7 single entry", {31'b0, redirect}, 32'd0);
    do_ret(); chk("R10 irq ret", redirect_pc, 32'h4440);
  endtask

  task automatic t_nmi();
    logic [31:0] v;
    do_nmi(32'h5000);
    chk("R9 vector", redirect_pc, 32'hBFC0_0000);
    rd(2'd0, v); chk("R9 erl bev", {30'b0, v[22], v[2]}, 32'd3);
    rd(2'd3, v); chk("R9 errorepc", v, 32'h5000);
    do_ret(); chk("R10 erl ret", redirect_pc, 32'h5000);
    rd(2'd0, v); chk("R10 erl cleared", {30'b0, v[2], v[1]}, 32'd0);
    take_exc(2'd0, 5'd9, 2'd0, 32'h6000, 1'b0);
    do_nmi(32'h7000);
    do_ret(); chk("R10 nested erl first", redirect_pc, 32'h7000);
    rd(2'd0, v); chk("R10 exl kept", {30'b0, v[2], v[1]}, 32'd1);
    do_ret(); chk("R10 nested exl next", redirect_pc, 32'h6000);
    rd(2'd0, v); chk("R10 all clear", {30'b0, v[2], v[1]}, 32'd0);
  endtask

  task automatic t_ll();
    ll_set = 1'b1; @(negedge clk); ll_set = 1'b0;
    chk("R11 ll set", {31'b0, ll_flag}, 32'd1);
    do_ret(); chk("R11 ll cleared", {31'b0, ll_flag}, 32'd0);
  endtask

  task automatic t_prio();
    logic [31:0] v;
    exc_req = 1'b1; exc_code = 5'd12; exc_kind = 2'd0;
    nmi_req = 1'b1; pc_in = 32'h7700;
    @(negedge clk); exc_req = 1'b0; nmi_req = 1'b0;
    chk("R12 nmi wins", redirect_pc, 32'hBFC0_0000);
    rd(2'd0, v); chk("R12 exl untouched", {31'b0, v[1]}, 32'd0);
    do_ret();
    csr_we = 1'b1; csr_sel = 2'd2; csr_wdata = 32'hDEAD_0000;
    take_exc(2'd0, 5'd10, 2'd0, 32'h8000, 1'b0);
    csr_we = 1'b0;
    rd(2'd2, v); chk("R12 write dropped", v, 32'h8000);
    do_ret();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_vectors();
    t_cause_code();
    t_epc();
    t_pending();
    t_irq();
    t_nmi();
    t_ll();
    t_prio();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule